// File: doc/BRIEF.md
# Interleaved DRAM Range Router

This block decides which memory node owns a physical DRAM address. It holds eight programmable address windows. Each window has two 32-bit registers: a lower-bound register and an upper-bound register. Each incoming 40-bit request is compared against all windows in parallel. The block returns a hit flag and the 3-bit node that serves the request. A window can be opened for reads, for writes, or for both.

A window can also take part in node interleaving. The lower-bound register selects which of address bits 14, 13 and 12 take part. The upper-bound register holds the value those bits must carry. Several windows can then cover the same span, with each one taking every second, fourth or eighth 4 KiB block. When windows overlap, the lowest-numbered window wins, and a separate multi-hit flag is raised so that overlaps can be caught.

Software programs the block through a single-cycle register port. A write takes effect at the clock edge. Read data is combinational. The route lookup is purely combinational from the request inputs and the stored registers.

Top module: `dram_region_router`

## Requirements
- R1: After a synchronous active-low reset, every register reads back as zero and no request hits.
- R2: Register select: `reg_addr[3:1]` is the window number and `reg_addr[0]` selects the register (0 = lower bound, 1 = upper bound). A write with `reg_we` high takes effect at the next rising edge. `reg_rdata` shows the selected register in the same cycle.
- R3: Writable bits are [31:16], [10:8] and [1:0] of the lower-bound register (read mask 0xFFFF0703), and [31:16], [10:8] and [2:0] of the upper-bound register (read mask 0xFFFF0707). All other bits ignore writes and read as zero.
- R4: A window covers a request only when lower[31:16] <= addr[39:24] <= upper[31:16], with both bounds inclusive.
- R5: A read request (`req_write`=0) needs lower bit 0 set, and a write request (`req_write`=1) needs lower bit 1 set. Otherwise the window does not hit.
- R6: The interleave code in lower[10:8] picks the address bits that are compared with upper[10:8]. Code 001 compares bit 12 only. Code 011 compares bits 14 and 12. Code 111 compares bits 14, 13 and 12. Code 000 compares nothing.
- R7: Any other interleave code (010, 100, 101, 110) behaves as code 000.
- R8: `node` equals upper[2:0] of the winning window, and is 0 when `hit` is low.
- R9: When several windows hit, the lowest-numbered one wins.
- R10: `multi_hit` is high exactly when two or more windows hit at once.
- R11: A window whose upper bound has been written but whose lower-bound enables are still zero never hits. Writing the lower bound with an enable arms the window from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Window number [3:1] and register select [0] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Selected register contents (combinational) |
| req_addr | input | 40 | Request physical address |
| req_write | input | 1 | Request direction: 1 = write, 0 = read |
| hit | output | 1 | Some window accepts the request |
| node | output | 3 | Destination node of the winning window |
| multi_hit | output | 1 | Two or more windows accept the request |

## Verification
Two functions can land in the same cycle, and the bench provokes both pairs.

- **Priority selection and overlap detection.** Windows are placed so that they overlap, including fully interleaved sets whose select values collide. The bench then expects both the lowest-index node and a raised `multi_hit` from the same lookup.
- **A register write and a lookup.** A lower-bound write that arms a window is issued while a request into that window is already applied. The output is judged against the old configuration before the edge and against the new one after it.

Every lookup, in the directed sweeps over all interleave codes and in the pseudo-random configurations, is compared with an arithmetic model of the requirements kept in the bench.

// File: rtl/drr_pkg.sv
// Package: shared constants, the decoded per-window configuration type and
// the interleave mask decode for the DRAM range router.
// Assumes 32-bit registers whose upper 16 bits carry address bits [39:24].
package drr_pkg;

    localparam int REG_W   = 32;
    localparam int HI_W    = 16;
    localparam int NODE_W  = 3;
    localparam int IL_W    = 3;

    localparam logic [REG_W-1:0] LOWER_WMASK = 32'hFFFF_0703;
    localparam logic [REG_W-1:0] UPPER_WMASK = 32'hFFFF_0707;

    typedef struct packed {
        logic [HI_W-1:0]   lo;       // first covered 16 MiB block
        logic [HI_W-1:0]   hi;       // last covered 16 MiB block
        logic              rd_en;
        logic              wr_en;
        logic [IL_W-1:0]   il_code;
        logic [IL_W-1:0]   il_sel;
        logic [NODE_W-1:0] node;
    } win_cfg_t;

    // Map an interleave code to the set of address bits [14:12] compared.
    // Undefined codes compare nothing.
    function automatic logic [IL_W-1:0] il_mask(input logic [IL_W-1:0] code);
        case (code)
            3'b001:  il_mask = 3'b001;
            3'b011:  il_mask = 3'b101;
            3'b111:  il_mask = 3'b111;
            default: il_mask = 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/drr_regfile.sv
// Register file: lower/upper bound register pairs for N_WIN windows.
// Unwritable bits are masked on entry, so they always read as zero.
// Assumes N_WIN is a power of two, so every index on reg_addr is valid.
module drr_regfile
    import drr_pkg::*;
#(
    parameter int N_WIN = 8,
    localparam int IDX_W = $clog2(N_WIN)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [IDX_W:0]             reg_addr,
    input  logic [REG_W-1:0]           reg_wdata,
    output logic [REG_W-1:0]           reg_rdata,
    output win_cfg_t [N_WIN-1:0]       cfg_o
);

    logic [N_WIN-1:0][REG_W-1:0] lower_q;
    logic [N_WIN-1:0][REG_W-1:0] upper_q;
    logic [IDX_W-1:0]            wr_idx;

    assign wr_idx = reg_addr[IDX_W:1];

    // Purpose: clear all registers on reset, capture masked write data otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lower_q <= '0;
            upper_q <= '0;
        end else if (reg_we) begin
            if (reg_addr[0]) upper_q[wr_idx] <= reg_wdata & UPPER_WMASK;
            else             lower_q[wr_idx] <= reg_wdata & LOWER_WMASK;
        end
    end

    // Purpose: combinational read of the addressed register.
    always_comb begin
        reg_rdata = reg_addr[0] ? upper_q[wr_idx] : lower_q[wr_idx];
    end

    // Purpose: unpack each register pair into named configuration fields.
    always_comb begin
        for (int i = 0; i < N_WIN; i++) begin
            cfg_o[i].lo      = lower_q[i][31:16];
            cfg_o[i].hi      = upper_q[i][31:16];
            cfg_o[i].rd_en   = lower_q[i][0];
            cfg_o[i].wr_en   = lower_q[i][1];
            cfg_o[i].il_code = lower_q[i][10:8];
            cfg_o[i].il_sel  = upper_q[i][10:8];
            cfg_o[i].node    = upper_q[i][2:0];
        end
    end

    // R2/R3: a write lands in the addressed register, masked, one edge later.
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> ((($past(reg_addr[0]) ? upper_q[$past(wr_idx)] : lower_q[$past(wr_idx)]))
                    == ($past(reg_wdata) & ($past(reg_addr[0]) ? UPPER_WMASK : LOWER_WMASK))));

endmodule

// File: rtl/drr_window_match.sv
// Window matcher: combinational test of one window against a request.
// It checks the inclusive block range, the direction enable and the
// interleave qualifier.
// Assumes the caller passes only address bits [39:24] and [14:12].
module drr_window_match
    import drr_pkg::*;
(
    input  win_cfg_t          cfg_i,
    input  logic [HI_W-1:0]   addr_hi_i,
    input  logic [IL_W-1:0]   addr_il_i,
    input  logic              wr_i,
    output logic              hit_o
);

    logic             in_range;
    logic             dir_ok;
    logic             il_ok;
    logic [IL_W-1:0]  msk;

    // Purpose: evaluate the three qualifiers and combine them.
    always_comb begin
        msk      = il_mask(cfg_i.il_code);
        in_range = (addr_hi_i >= cfg_i.lo) && (addr_hi_i <= cfg_i.hi);
        dir_ok   = wr_i ? cfg_i.wr_en : cfg_i.rd_en;
        il_ok    = ((addr_il_i ^ cfg_i.il_sel) & msk) == '0;
        hit_o    = in_range && dir_ok && il_ok;
    end

endmodule

// File: rtl/drr_prio_sel.sv
// Priority selector: picks the lowest-numbered asserted window and flags
// cases where more than one window asserts.
// Assumes the hit vector is stable within a cycle (combinational path).
module drr_prio_sel #(
    parameter int N_WIN = 8,
    localparam int IDX_W = $clog2(N_WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_WIN-1:0] hit_vec,
    output logic [IDX_W-1:0] win_idx,
    output logic             any_hit,
    output logic             multi_hit
);

    // Purpose: scan from the top so that the lowest set index wins.
    always_comb begin
        win_idx = '0;
        for (int i = N_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) win_idx = IDX_W'(i);
        end
    end

    // Purpose: any-hit, and multi-hit from clearing the lowest set bit.
    always_comb begin
        any_hit   = |hit_vec;
        multi_hit = (hit_vec & (hit_vec - 1'b1)) != '0;
    end

    // R9: the selected window hits and no lower window does.
    a_r9_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |-> (hit_vec[win_idx]
                     && ((hit_vec & ((N_WIN'(1) << win_idx) - 1'b1)) == '0)));

    // R10: the overlap flag agrees with a population count.
    a_r10_multi_count: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit == ($countones(hit_vec) > 1));

endmodule

// File: rtl/dram_region_router.sv
// Top: DRAM range router. Eight programmable windows route a 40-bit request
// address to a destination node. Each window has its own direction enables
// and an optional interleave qualifier on address bits [14:12]. The lookup
// is combinational; register writes take effect at the clock edge.
// Assumes N_WIN is a power of two and ADDR_W is at least 40.
module dram_region_router
    import drr_pkg::*;
#(
    parameter int N_WIN  = 8,
    parameter int ADDR_W = 40,
    localparam int IDX_W  = $clog2(N_WIN),
    localparam int HI_LSB = ADDR_W - HI_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [IDX_W:0]      reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic                req_write,
    output logic                hit,
    output logic [NODE_W-1:0]   node,
    output logic                multi_hit
);

    win_cfg_t [N_WIN-1:0] cfg;
    logic [N_WIN-1:0]     hit_vec;
    logic [IDX_W-1:0]     win_idx;
    logic                 any_hit;
    logic [HI_W-1:0]      addr_hi;
    logic [IL_W-1:0]      addr_il;
    logic                 unused_addr_bits;

    assign addr_hi          = req_addr[ADDR_W-1:HI_LSB];
    assign addr_il          = req_addr[14:12];
    assign unused_addr_bits = ^{req_addr[HI_LSB-1:15], req_addr[11:0]};

    drr_regfile #(.N_WIN(N_WIN)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .cfg_o     (cfg)
    );

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        drr_window_match u_match (
            .cfg_i     (cfg[g]),
            .addr_hi_i (addr_hi),
            .addr_il_i (addr_il),
            .wr_i      (req_write),
            .hit_o     (hit_vec[g])
        );
    end

    drr_prio_sel #(.N_WIN(N_WIN)) u_prio (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_vec   (hit_vec),
        .win_idx   (win_idx),
        .any_hit   (any_hit),
        .multi_hit (multi_hit)
    );

    // Purpose: drive the route outputs from the winning window.
    always_comb begin
        hit  = any_hit;
        node = any_hit ? cfg[win_idx].node : '0;
    end

    // R4: a routed request lies inside the winner's block range.
    a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((cfg[win_idx].lo <= addr_hi) && (addr_hi <= cfg[win_idx].hi)));

    // R5: a routed request's direction is enabled in the winner.
    a_r5_dir_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (req_write ? cfg[win_idx].wr_en : cfg[win_idx].rd_en));

    // R8: no route means node zero.
    a_r8_idle_node: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (node == '0));

endmodule

// File: tb/sim_dram_region_router.sv
`timescale 1ns/1ps
module sim_dram_region_router;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [39:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        hit;
    logic [2:0]  node;
    logic        multi_hit;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] seed = 32'h1234_5678;

    logic [31:0] lower_m [8];
    logic [31:0] upper_m [8];

    localparam logic [31:0] LMASK = 32'hFFFF0703;
    localparam logic [31:0] UMASK = 32'hFFFF0707;

    always #4 clk = ~clk;

    dram_region_router u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_addr(req_addr),
        .req_write(req_write), .hit(hit), .node(node), .multi_hit(multi_hit)
    );

    function automatic logic [31:0] rnd();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    // Reference model built from R4..R10.
    function automatic void model(input logic [39:0] a, input logic w,
                                  output logic h, output logic [2:0] n, output logic m);
        int cnt = 0;
        h = 1'b0; n = 3'd0;
        for (int i = 0; i < 8; i++) begin
            logic [2:0] msk;
            logic en, inr, ok;
            case (lower_m[i][10:8])
                3'd1: msk = 3'b001;
                3'd3: msk = 3'b101;
                3'd7: msk = 3'b111;
                default: msk = 3'b000;
            endcase
            en  = w ? lower_m[i][1] : lower_m[i][0];
            inr = (a[39:24] >= lower_m[i][31:16]) && (a[39:24] <= upper_m[i][31:16]);
            ok  = ((a[14:12] ^ upper_m[i][10:8]) & msk) == 3'b000;
            if (en && inr && ok) begin
                cnt++;
                if (!h) begin h = 1'b1; n = upper_m[i][2:0]; end
            end
        end
        m = (cnt > 1);
    endfunction

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a[0]) upper_m[a[3:1]] = d & UMASK;
        else      lower_m[a[3:1]] = d & LMASK;
    endtask

    // Upper bound first, lower bound (with enables) last.
    task automatic set_win(input int i, input logic [15:0] lo, input logic [15:0] hi,
                           input logic rd, input logic we, input logic [2:0] code,
                           input logic [2:0] sel, input logic [2:0] nd);
        wr(4'(2*i+1), {hi, 5'd0, sel, 5'd0, nd});
        wr(4'(2*i),   {lo, 5'd0, code, 6'd0, we, rd});
    endtask

    task automatic clear_all();
        for (int i = 0; i < 8; i++) begin
            wr(4'(2*i), 32'h0);
            wr(4'(2*i+1), 32'h0);
        end
    endtask

    task automatic look(input string tag, input logic [39:0] a, input logic w);
        logic eh, em;
        logic [2:0] en;
        @(negedge clk);
        req_addr = a; req_write = w;
        #2;
        model(a, w, eh, en, em);
        checks++;
        if (hit !== eh || node !== en || multi_hit !== em) begin
            errors++;
            $display("FAIL %s addr=%h wr=%0b got hit=%0b node=%0d multi=%0b exp hit=%0b node=%0d multi=%0b",
                     tag, a, w, hit, node, multi_hit, eh, en, em);
        end
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] e);
        @(negedge clk);
        reg_addr = a;
        #2;
        checks++;
        if (reg_rdata !== e) begin
            errors++;
            $display("FAIL %s reg=%0d got %h exp %h", tag, a, reg_rdata, e);
        end
    endtask

    function automatic logic [39:0] mk(input logic [15:0] blk, input logic [2:0] il, input logic [31:0] r);
        return {blk, r[8:0], il, r[11:0]};
    endfunction

    initial begin
        for (int i = 0; i < 8; i++) begin lower_m[i] = '0; upper_m[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int r = 0; r < 16; r++) rd_chk("R1 reset readback", 4'(r), 32'h0);
        look("R1 reset no read hit", 40'h00_0000_0000, 1'b0);
        look("R1 reset no write hit", 40'h00_0000_0000, 1'b1);

        // R2/R3: register select and writable-bit masks
        wr(4'd0, 32'hFFFF_FFFF);
        wr(4'd1, 32'hFFFF_FFFF);
        rd_chk("R3 lower mask", 4'd0, 32'hFFFF0703);
        rd_chk("R3 upper mask", 4'd1, 32'hFFFF0707);
        wr(4'd13, 32'hA5A5_5A5A);
        rd_chk("R2 window6 upper", 4'd13, 32'hA5A5_5A5A & UMASK);
        rd_chk("R2 window6 lower untouched", 4'd12, 32'h0);
        clear_all();

        // R11: upper first leaves window dark; lower write arms it next cycle
        wr(4'd5, {16'h0020, 5'd0, 3'd0, 5'd0, 3'd5});
        look("R11 upper only no hit", mk(16'h0018, 3'd0, 32'h0), 1'b0);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'd4; reg_wdata = {16'h0010, 16'h0001};
        req_addr = mk(16'h0018, 3'd0, 32'h0); req_write = 1'b0;
        #2;
        checks++;
        if (hit !== 1'b0) begin
            errors++;
            $display("FAIL R11 same-cycle write got hit=%0b exp hit=0", hit);
        end
        @(negedge clk);
        reg_we = 1'b0;
        lower_m[2] = {16'h0010, 16'h0001} & LMASK;
        look("R11 armed after write", mk(16'h0018, 3'd0, 32'h0), 1'b0);
        look("R5 write blocked", mk(16'h0018, 3'd0, 32'h0), 1'b1);

        // R4: inclusive bounds
        look("R4 below base", mk(16'h000F, 3'd0, 32'h0), 1'b0);
        look("R4 at base", mk(16'h0010, 3'd0, 32'h0), 1'b0);
        look("R4 at limit", mk(16'h0020, 3'd0, 32'hFFFF_FFFF), 1'b0);
        look("R4 above limit", mk(16'h0021, 3'd0, 32'h0), 1'b0);

        // R5: write-only window
        set_win(2, 16'h0010, 16'h0020, 1'b0, 1'b1, 3'd0, 3'd0, 3'd6);
        look("R5 read blocked", mk(16'h0015, 3'd0, 32'h0), 1'b0);
        look("R5 write allowed", mk(16'h0015, 3'd0, 32'h0), 1'b1);
        clear_all();

        // R6/R8: full 8-way interleave, window i takes select i and node 7-i
        for (int i = 0; i < 8; i++)
            set_win(i, 16'h0100, 16'h01FF, 1'b1, 1'b1, 3'd7, 3'(i), 3'(7-i));
        for (int v = 0; v < 8; v++) begin
            look("R6 8-way read", mk(16'h0180, 3'(v), rnd()), 1'b0);
            look("R8 8-way write", mk(16'h01FF, 3'(v), rnd()), 1'b1);
        end
        // R6: 4-way (bits 14,12) and 2-way (bit 12) interleave
        for (int i = 0; i < 8; i++)
            set_win(i, 16'h0100, 16'h01FF, 1'b1, 1'b1, (i < 4) ? 3'd3 : 3'd1,
                    (i < 4) ? 3'(i) : 3'(i + 1), 3'(i));
        for (int v = 0; v < 8; v++) look("R6 4-way/2-way", mk(16'h0120, 3'(v), rnd()), 1'b0);
        clear_all();

        // R7: undefined codes compare nothing
        set_win(3, 16'h0040, 16'h0040, 1'b1, 1'b0, 3'd2, 3'd5, 3'd3);
        set_win(5, 16'h0050, 16'h0050, 1'b1, 1'b0, 3'd6, 3'd1, 3'd4);
        for (int v = 0; v < 8; v++) begin
            look("R7 code 010", mk(16'h0040, 3'(v), rnd()), 1'b0);
            look("R7 code 110", mk(16'h0050, 3'(v), rnd()), 1'b0);
        end
        clear_all();

        // R9/R10: overlapping windows
        set_win(6, 16'h0000, 16'h00FF, 1'b1, 1'b1, 3'd0, 3'd0, 3'd1);
        set_win(4, 16'h0010, 16'h0020, 1'b1, 1'b1, 3'd0, 3'd0, 3'd2);
        set_win(1, 16'h0018, 16'h0018, 1'b1, 1'b1, 3'd0, 3'd0, 3'd7);
        look("R10 single hit", mk(16'h0030, 3'd0, 32'h0), 1'b0);
        look("R9 two overlap lower wins", mk(16'h0011, 3'd0, 32'h0), 1'b0);
        look("R9 three overlap lowest wins", mk(16'h0018, 3'd0, 32'h0), 1'b1);
        look("R10 no hit", mk(16'h0100, 3'd0, 32'h0), 1'b0);
        clear_all();

        // Mixed pseudo-random configurations, reserved bits included (R3..R10)
        for (int c = 0; c < 24; c++) begin
            for (int i = 0; i < 8; i++) begin
                logic [15:0] lo, hi;
                lo = 16'(rnd() % 8);
                hi = lo + 16'(rnd() % 4);
                wr(4'(2*i+1), {hi, rnd() & 32'h0000FFFF});
                wr(4'(2*i),   {lo, rnd() & 32'h0000FFFF});
            end
            for (int r = 0; r < 16; r++)
                rd_chk("R3 random readback", 4'(r), r[0] ? upper_m[r/2] : lower_m[r/2]);
            for (int k = 0; k < 48; k++) begin
                logic [31:0] x;
                x = rnd();
                look("R9 random lookup", mk(16'(x % 12), x[18:16], rnd()), x[20]);
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got running exp finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule